// File: doc/BRIEF.md
# Parallel Prefix OR Tree

This block takes a vector of single-bit flags and returns every running OR over it. Each result answers one question: "is any flag set at or below this position?". Typical uses are leading-one masks, first-hit detection and thermometer-code generation. The block is purely combinational, with no clock and no reset. A downstream register stage samples the results wherever the surrounding pipeline needs them.

The block uses only 2-input OR cells, laid out as a logarithmic prefix tree. In stage `s`, each position whose index has bit `s` set takes the OR with the last position of the block of size 2^s just below it. With eight inputs this needs three stages of four cells each. That is twelve cells in total, and no input passes through more than three of them. A serial chain would need only seven cells, but its longest path would be seven cells deep. The bit-0 result is also brought out unchanged, so the full set of eight prefixes is available.

Top module: `prefix_or_tree`

## Requirements
- R1: `prefix_o[k]` equals the OR of `bits_i[0]` through `bits_i[k+1]`, for every k from 0 to WIDTH-2.
- R2: The prefix results are monotonic. If `prefix_o[k]` is 1, then every `prefix_o[j]` with j > k is also 1.
- R3: `prefix_o[WIDTH-2]` equals the OR of the whole input vector.
- R4: An all-zero input gives all-zero `prefix_o` and `lead_o` outputs.
- R5: `lead_o` always equals `bits_i[0]`.
- R6: A set input bit j (j ≥ 2) whose lower bits are all zero has no effect on `prefix_o[k]` for k < j-1. Those outputs stay 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bits_i | input | WIDTH (8) | Flags to be scanned; index 0 is the start of every prefix |
| lead_o | output | 1 | Prefix of length one (copy of bit 0) |
| prefix_o | output | WIDTH-1 (7) | Bit k is the OR of input bits 0 through k+1 |

## Verification
The bench builds the tree with the default WIDTH of 8. At that width there are only 256 input patterns, so it applies every one of them. Each output bit is compared with a running OR computed in a loop. The sweep therefore covers every case of the first set bit at every position, which includes the masking condition of R6 and the all-zero corner of R4. The depth-three structure itself is not visible at the ports, so the checks confirm the function while the tree shape is fixed by construction.

// File: rtl/prefix_or_pkg.sv
package prefix_or_pkg;

  // Number of tree stages needed to cover a vector of w bits.
  function automatic int unsigned stage_count(input int unsigned w);
    int unsigned s;
    s = 0;
    while ((1 << s) < w) s++;
    return s;
  endfunction

  // Returns the source position that position idx combines with in stage s.
  // This is the top position of the lower half of the block of size 2^(s+1).
  function automatic int unsigned partner_of(input int unsigned idx, input int unsigned s);
    return ((idx >> s) << s) - 1;
  endfunction

  // Reports whether position idx takes a new cell in stage s.
  function automatic bit takes_cell(input int unsigned idx, input int unsigned s);
    return ((idx >> s) & 1) == 1;
  endfunction

endpackage

// File: rtl/por_or2.sv
module por_or2 (
  input  logic a_i,
  input  logic b_i,
  output logic y_o
);
  assign y_o = a_i | b_i;
endmodule

// File: rtl/por_stage.sv
module por_stage #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned STAGE = 0
) (
  input  logic [WIDTH-1:0] in_v,
  output logic [WIDTH-1:0] out_v
);
  import prefix_or_pkg::*;

  for (genvar i = 0; i < WIDTH; i++) begin : g_pos
    if (takes_cell(i, STAGE)) begin : g_cell
      localparam int unsigned SRC = partner_of(i, STAGE);
      por_or2 u_or (
        .a_i (in_v[i]),
        .b_i (in_v[SRC]),
        .y_o (out_v[i])
      );
    end else begin : g_pass
      assign out_v[i] = in_v[i];
    end
  end
endmodule

// File: rtl/prefix_or_tree.sv
module prefix_or_tree #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] bits_i,
  output logic             lead_o,
  output logic [WIDTH-2:0] prefix_o
);
  import prefix_or_pkg::*;

  localparam int unsigned STAGES = stage_count(WIDTH);

  logic [WIDTH-1:0] stage_v [0:STAGES];

  assign stage_v[0] = bits_i;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    por_stage #(
      .WIDTH (WIDTH),
      .STAGE (s)
    ) u_stage (
      .in_v  (stage_v[s]),
      .out_v (stage_v[s+1])
    );
  end

  assign lead_o   = stage_v[STAGES][0];
  assign prefix_o = stage_v[STAGES][WIDTH-1:1];
endmodule

// File: rtl/prefix_or_tree_chk.sv
module prefix_or_tree_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic [WIDTH-1:0] bits_i,
  input logic             lead_o,
  input logic [WIDTH-2:0] prefix_o
);
  always_comb begin
    if (!$isunknown(bits_i)) begin
      for (int k = 0; k < WIDTH - 1; k++) begin
        p_running_or_r1: assert (prefix_o[k] == (|(bits_i & ((2 << (k + 1)) - 1))));
      end
      for (int k = 0; k < WIDTH - 2; k++) begin
        p_monotonic_r2: assert (!prefix_o[k] || prefix_o[k+1]);
      end
      p_full_or_r3: assert (prefix_o[WIDTH-2] == (bits_i != '0));
      p_zero_in_r4: assert ((bits_i != '0) || ((prefix_o == '0) && !lead_o));
      p_lead_copy_r5: assert (lead_o == bits_i[0]);
    end
  end
endmodule

bind prefix_or_tree prefix_or_tree_chk #(.WIDTH(WIDTH)) u_chk (
  .bits_i   (bits_i),
  .lead_o   (lead_o),
  .prefix_o (prefix_o)
);

// File: tb/test_prefix_or_tree.sv
module test_prefix_or_tree;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic [W-1:0] bits_i;
  logic         lead_o;
  logic [W-2:0] prefix_o;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  prefix_or_tree #(.WIDTH(W)) i_prefix_or_tree (
    .bits_i   (bits_i),
    .lead_o   (lead_o),
    .prefix_o (prefix_o)
  );

  task automatic check_bit(input string req, input int idx, input logic act, input logic exp);
    if (act !== exp) begin
      errors++;
      $display("FAIL %s in=%b bit %0d actual=%b expected=%b", req, bits_i, idx, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin : stim
    // R4: the all-zero pattern is applied first, standing in for a reset state.
    bits_i = '0;
    @(negedge clk);
    vectors++;
    check_bit("R4", -1, lead_o, 1'b0);
    for (int k = 0; k < W - 1; k++) check_bit("R4", k, prefix_o[k], 1'b0);

    for (int v = 0; v < (1 << W); v++) begin
      logic run;
      logic [W-1:0] pat;
      int first;
      pat = W'(v);
      @(posedge clk);
      bits_i = pat;
      @(negedge clk);
      vectors++;
      // R5: lead_o is a copy of bit 0.
      check_bit("R5", -1, lead_o, pat[0]);
      // R1: running OR computed in a loop.
      run = pat[0];
      for (int k = 0; k < W - 1; k++) begin
        run = run | pat[k+1];
        check_bit("R1", k, prefix_o[k], run);
      end
      // R2: once an output is set, every higher output is set too.
      for (int k = 0; k < W - 2; k++)
        if (prefix_o[k] === 1'b1) check_bit("R2", k + 1, prefix_o[k+1], 1'b1);
      // R3: the top output equals the OR of the whole vector.
      check_bit("R3", W - 2, prefix_o[W-2], (v != 0) ? 1'b1 : 1'b0);
      // R6: the outputs below the first set bit stay low.
      first = W;
      for (int j = W - 1; j >= 0; j--) if (pat[j]) first = j;
      if (first >= 2 && first < W)
        for (int k = 0; k < first - 1; k++) check_bit("R6", k, prefix_o[k], 1'b0);
      // R4: the all-zero pattern produces all-zero outputs.
      if (v == 0) check_bit("R4", -2, |prefix_o, 1'b0);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule